// File: doc/BRIEF.md
# Host-Cleared User Interrupt Controller

This block collects interrupt requests from user logic and presents them to the user-interrupt request lines of a PCIe DMA engine. A low-to-high transition on any request bit marks that interrupt as pending. Each pending bit is gated by a per-bit enable and driven out as a request line. The bit stays up until the host driver services it.

The host reaches the block over an AXI4-Lite slave that is mapped into its user address space. Word 0x00 reads the pending set. Word 0x04 takes write-one-to-clear commands. Word 0x08 holds the enable mask. The acknowledge returned by the DMA engine does not retire a pending bit. Only an explicit host clear does, so an interrupt the driver has not yet seen cannot be lost.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, irq_o is all zeros, the pending word (0x00) reads 0 and the enable word (0x08) reads 0x0000FFFF.
- R2: A request bit that is low at one rising clock edge and high at the next sets its pending bit at that later edge. A request held high after its bit was cleared does not set it again.
- R3: irq_o equals pending AND enable. Enable is read/write at 0x08. Bits 31:16 of 0x00 and 0x08 read zero.
- R4: A write to 0x04 clears each pending bit whose write-data bit is 1 in a byte lane whose wstrb bit is 1. Other bits keep their value. Writes to 0x08 also honour wstrb byte lanes.
- R5: If a rising request and a host clear hit the same bit at the same edge, the bit stays pending.
- R6: irq_ack_i has no effect. A driven irq_o bit stays high for any acknowledge pattern until the host clears it or masks it.
- R7: Writes to 0x00, to 0x0C and above, and to non-word-aligned addresses change no state. Reads from 0x04, from unmapped addresses and from non-word-aligned addresses return 0.
- R8: The write address and write data may arrive in either order or together. Each write gets exactly one response, and bvalid_o stays high until bready_i is sampled high.
- R9: bresp_o and rresp_o are always OKAY (2'b00). rvalid_o and rdata_o stay stable until rready_i is sampled high.
- R10: A read of 0x00 returns the pending set as it stood at the edge on which the read address was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Interrupt requests from user logic |
| irq_ack_i | input | 16 | Acknowledge from the DMA engine (no effect) |
| irq_o | output | 16 | Interrupt request lines to the DMA engine |
| s_awaddr_i | input | 8 | AXI4-Lite write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 8 | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |

## Verification
The bench times a rising request to land on the same edge as a clear commit. A design that let the clear win would silently drop that interrupt. It clears a bit while its request is still held high, which catches level capture that would re-raise the interrupt at once. It also toggles the DMA acknowledge, which exposes any path that retires a bit without the host. Write tests use address-first, data-first and simultaneous arrival, partial byte strobes, and stalled response and read-data channels. These expose a slave that deadlocks on one ordering, ignores the strobes, or drops or changes a held response.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_CLR  = 2'd1,
    REG_EN   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // word index decode; misaligned addresses map nowhere
  function automatic reg_sel_e decode_addr(input logic [1:0] byte_off, input int unsigned word_idx);
    if (byte_off != 2'b00) return REG_NONE;
    case (word_idx)
      0:       return REG_PEND;
      1:       return REG_CLR;
      2:       return REG_EN;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uirq_edge_det.sv
module uirq_edge_det #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/uirq_irq_regs.sv
module uirq_irq_regs
  import uirq_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] rise_i,
  input  logic             wr_en_i,
  input  reg_sel_e         wr_sel_i,
  input  logic [N_IRQ-1:0] wr_data_i,
  input  logic [N_IRQ-1:0] wr_mask_i,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] en_o
);
  logic [N_IRQ-1:0] pend_q, en_q, clr_w;

  assign clr_w = (wr_en_i && wr_sel_i == REG_CLR) ? (wr_data_i & wr_mask_i) : '0;

  // a new rising request overrides a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_w) | rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '1;
    else if (wr_en_i && wr_sel_i == REG_EN)
      en_q <= (en_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/uirq_axil_slave.sv
module uirq_axil_slave
  import uirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_IRQ  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic [N_IRQ-1:0]  pend_i,
  input  logic [N_IRQ-1:0]  en_i,
  output logic              wr_en_o,
  output reg_sel_e          wr_sel_o,
  output logic [N_IRQ-1:0]  wr_data_o,
  output logic [N_IRQ-1:0]  wr_mask_o
);
  localparam int unsigned STRB_W = DATA_W / 8;

  logic              aw_full_q, w_full_q, bvalid_q, rvalid_q, wr_fire;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [DATA_W-1:0] w_data_q, rdata_q, bit_mask;
  logic [STRB_W-1:0] w_strb_q;
  reg_sel_e          rd_sel;

  assign awready_o = ~aw_full_q;
  assign wready_o  = ~w_full_q;
  assign arready_o = ~rvalid_q;
  assign wr_fire   = aw_full_q & w_full_q & ~bvalid_q;

  // address and data are held independently, so either may come first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      aw_addr_q <= '0;
    end else if (awvalid_i && !aw_full_q) begin
      aw_full_q <= 1'b1;
      aw_addr_q <= awaddr_i;
    end else if (wr_fire) begin
      aw_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_full_q <= 1'b0;
      w_data_q <= '0;
      w_strb_q <= '0;
    end else if (wvalid_i && !w_full_q) begin
      w_full_q <= 1'b1;
      w_data_q <= wdata_i;
      w_strb_q <= wstrb_i;
    end else if (wr_fire) begin
      w_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bvalid_q <= 1'b0;
    else if (wr_fire)  bvalid_q <= 1'b1;
    else if (bready_i) bvalid_q <= 1'b0;
  end

  assign rd_sel = decode_addr(araddr_i[1:0], int'(araddr_i[ADDR_W-1:2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && !rvalid_q) begin
      rvalid_q <= 1'b1;
      case (rd_sel)
        REG_PEND: rdata_q <= DATA_W'(pend_i);
        REG_EN:   rdata_q <= DATA_W'(en_i);
        default:  rdata_q <= '0;
      endcase
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign bit_mask[b] = w_strb_q[b/8];
  end

  if (DATA_W > N_IRQ) begin : g_unused
    logic unused_upper;
    assign unused_upper = ^{w_data_q[DATA_W-1:N_IRQ], bit_mask[DATA_W-1:N_IRQ]};
  end

  assign wr_en_o   = wr_fire;
  assign wr_sel_o  = decode_addr(aw_addr_q[1:0], int'(aw_addr_q[ADDR_W-1:2]));
  assign wr_data_o = w_data_q[N_IRQ-1:0];
  assign wr_mask_o = bit_mask[N_IRQ-1:0];
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rresp_o   = RESP_OKAY;
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic [N_IRQ-1:0]  irq_ack_i,
  output logic [N_IRQ-1:0]  irq_o,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [DATA_W/8-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i
);
  logic [N_IRQ-1:0] rise_w, pend_w, en_w, wr_data_w, wr_mask_w;
  logic             wr_en_w;
  reg_sel_e         wr_sel_w;

  // acknowledge never retires an interrupt; only the host clear does
  logic unused_ack;
  assign unused_ack = ^irq_ack_i;

  uirq_edge_det #(.WIDTH(N_IRQ)) u_edge (
    .clk_i, .rst_ni, .level_i(irq_req_i), .rise_o(rise_w)
  );

  uirq_irq_regs #(.N_IRQ(N_IRQ)) u_regs (
    .clk_i, .rst_ni,
    .rise_i(rise_w), .wr_en_i(wr_en_w), .wr_sel_i(wr_sel_w),
    .wr_data_i(wr_data_w), .wr_mask_i(wr_mask_w),
    .pend_o(pend_w), .en_o(en_w)
  );

  uirq_axil_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IRQ(N_IRQ)) u_axil (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .pend_i(pend_w), .en_i(en_w),
    .wr_en_o(wr_en_w), .wr_sel_o(wr_sel_w), .wr_data_o(wr_data_w), .wr_mask_o(wr_mask_w)
  );

  assign irq_o = pend_w & en_w;
endmodule

// File: rtl/uirq_ctrl_sva.sv
module uirq_ctrl_sva #(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_IRQ-1:0]  irq_req_i,
  input logic [N_IRQ-1:0]  irq_o,
  input logic [N_IRQ-1:0]  pend_i,
  input logic              bvalid_i,
  input logic              bready_i,
  input logic [1:0]        bresp_i,
  input logic              rvalid_i,
  input logic              rready_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic [1:0]        rresp_i
);
  a_r3_out_within_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~pend_i) == '0);

  a_r8_bvalid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_i && !bready_i) |=> bvalid_i);

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_i && !rready_i) |=> (rvalid_i && $stable(rdata_i)));

  a_r9_bresp_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_i |-> bresp_i == 2'b00);

  a_r9_rresp_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> rresp_i == 2'b00);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    // R2: a rising request is pending one edge later
    a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_req_i[i]) |=> pend_i[i]);
    // R6: pending only drops on the edge that issues a write response
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[i] |=> (pend_i[i] || $rose(bvalid_i)));
  end
endmodule

bind uirq_ctrl uirq_ctrl_sva #(.N_IRQ(N_IRQ), .DATA_W(DATA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .irq_o(irq_o),
  .pend_i(pend_w), .bvalid_i(s_bvalid_o), .bready_i(s_bready_i), .bresp_i(s_bresp_o),
  .rvalid_i(s_rvalid_o), .rready_i(s_rready_i), .rdata_i(s_rdata_o), .rresp_i(s_rresp_o)
);

// File: tb/uirq_ctrl_tb_top.sv
module uirq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq_req_i = '0, irq_ack_i = '0, irq_o;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, awready, wvalid = 0, wready, bvalid, bready = 1;
  logic        arvalid = 0, arready, rvalid, rready = 1;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  wstrb = '0;
  logic [1:0]  bresp, rresp;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_pend = '0, m_en = 16'hFFFF, m_prev = '0;
  logic [7:0]  m_wa;
  logic [31:0] m_wd;
  logic [3:0]  m_ws;

  always #4 clk_i = ~clk_i;

  uirq_ctrl dut_i (
    .clk_i, .rst_ni, .irq_req_i, .irq_ack_i, .irq_o,
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[7:2])
      6'd0:    return {16'h0, m_pend};
      6'd2:    return {16'h0, m_en};
      default: return '0;
    endcase
  endfunction

  // one clock: advance model by the edge, then compare irq_o
  task automatic tick();
    logic [15:0] rq, clr, mask;
    logic        bv0;
    rq = irq_req_i; bv0 = bvalid; clr = '0;
    @(posedge clk_i); #2;
    if (!bv0 && bvalid) begin
      for (int b = 0; b < 16; b++) mask[b] = m_ws[b/8];
      if (m_wa == 8'h04) clr = m_wd[15:0] & mask;
      else if (m_wa == 8'h08) m_en = (m_en & ~mask) | (m_wd[15:0] & mask);
    end
    m_pend = (m_pend & ~clr) | (rq & ~m_prev);
    m_prev = rq;
    chk("R3 irq_o vs model", {16'h0, irq_o}, {16'h0, m_pend & m_en});
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int order, input int bdelay, input int rise_bit);
    bit aw_done = 0, w_done = 0, first = 1;
    int guard = 0;
    m_wa = a; m_wd = d; m_ws = s;
    awaddr = a; wdata = d; wstrb = s;
    bready = (bdelay == 0);
    awvalid = (order != 2);
    wvalid  = (order != 1);
    while (!(aw_done && w_done) && guard < 20) begin
      bit aw_hs, w_hs;
      aw_hs = awvalid & awready;
      w_hs  = wvalid & wready;
      tick();
      guard++;
      if (aw_hs) begin awvalid = 0; aw_done = 1; end
      if (w_hs)  begin wvalid = 0;  w_done = 1;  end
      if (first && rise_bit >= 0) irq_req_i[rise_bit] = 1'b1;
      first = 0;
      if (order == 1 && aw_done && !w_done) wvalid = 1;
      if (order == 2 && w_done && !aw_done) awvalid = 1;
    end
    chk("R8 write handshakes complete", {31'h0, aw_done & w_done}, 32'h1);
    guard = 0;
    while (!bvalid && guard < 10) begin tick(); guard++; end
    chk("R8 bvalid raised", {31'h0, bvalid}, 32'h1);
    chk("R9 bresp OKAY", {30'h0, bresp}, 32'h0);
    for (int k = 0; k < bdelay; k++) begin
      tick();
      chk("R8 bvalid held while bready low", {31'h0, bvalid}, 32'h1);
    end
    bready = 1;
    tick();
    chk("R8 single response", {31'h0, bvalid}, 32'h0);
  endtask

  task automatic axi_rd(input string req, input logic [7:0] a, input int rdelay);
    logic [31:0] exp, held;
    int guard = 0;
    araddr = a; arvalid = 1; rready = (rdelay == 0);
    exp = m_read(a);
    tick();
    arvalid = 0;
    while (!rvalid && guard < 10) begin tick(); guard++; end
    chk(req, rdata, exp);
    chk("R9 rresp OKAY", {30'h0, rresp}, 32'h0);
    held = rdata;
    for (int k = 0; k < rdelay; k++) begin
      tick();
      chk("R9 rvalid held", {31'h0, rvalid}, 32'h1);
      chk("R9 rdata stable", rdata, held);
    end
    rready = 1;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    chk("R1 irq_o after reset", {16'h0, irq_o}, 32'h0);
    axi_rd("R1 enable reset value", 8'h08, 0);
    axi_rd("R1 pending reset value", 8'h00, 0);

    // R2: pulse capture and level-held clear
    irq_req_i[0] = 1; tick(); irq_req_i[0] = 0; tick();
    chk("R2 pulse captured", {31'h0, irq_o[0]}, 32'h1);
    irq_req_i[5] = 1; tick(); tick();
    axi_wr(8'h04, 32'h0000_0020, 4'hF, 0, 0, -1);
    repeat (3) tick();
    chk("R2 held level not recaptured", {31'h0, irq_o[5]}, 32'h0);
    irq_req_i[5] = 0; tick();
    axi_wr(8'h04, 32'h0000_0001, 4'hF, 1, 0, -1);

    // R4: byte strobes on clear
    irq_req_i[1] = 1; irq_req_i[9] = 1; tick();
    irq_req_i[1] = 0; irq_req_i[9] = 0; tick();
    axi_wr(8'h04, 32'h0000_0202, 4'b0001, 2, 0, -1);
    axi_rd("R4 strobe-limited clear", 8'h00, 0);
    chk("R4 lane1 bit kept", {31'h0, irq_o[9]}, 32'h1);

    // R3: mask hides output but not pending
    axi_wr(8'h08, 32'hFFFF_00FF, 4'hF, 0, 2, -1);
    chk("R3 masked bit low", {31'h0, irq_o[9]}, 32'h0);
    axi_rd("R3 enable readback, upper zero", 8'h08, 0);
    axi_rd("R10 pending visible under mask", 8'h00, 1);
    axi_wr(8'h08, 32'h0000_FF00, 4'b0010, 1, 0, -1);
    chk("R3 unmasked bit high", {31'h0, irq_o[9]}, 32'h1);

    // R5: rise lands on the clear commit edge
    irq_req_i[3] = 1; tick(); irq_req_i[3] = 0; tick();
    axi_wr(8'h04, 32'h0000_0008, 4'hF, 0, 0, 3);
    chk("R5 set wins over clear", {31'h0, irq_o[3]}, 32'h1);
    irq_req_i[3] = 0; tick();

    // R6: acknowledge does nothing
    irq_ack_i = 16'hFFFF; repeat (4) tick();
    irq_ack_i = 16'h0208; tick();
    irq_ack_i = '0; tick();
    chk("R6 outputs kept after ack", {16'h0, irq_o}, 32'h0000_0208);

    // R7: writes to read-only/unmapped/misaligned, unmapped reads
    axi_wr(8'h00, 32'h0000_FFFF, 4'hF, 0, 0, -1);
    axi_wr(8'h0C, 32'h0000_FFFF, 4'hF, 2, 0, -1);
    axi_wr(8'h05, 32'h0000_FFFF, 4'hF, 1, 0, -1);
    axi_wr(8'h09, 32'h0000_0000, 4'hF, 0, 0, -1);
    axi_rd("R7 pending unchanged by ignored writes", 8'h00, 0);
    axi_rd("R7 enable unchanged by ignored writes", 8'h08, 0);
    axi_rd("R7 clear word reads zero", 8'h04, 0);
    axi_rd("R7 unmapped reads zero", 8'h40, 0);
    axi_rd("R7 misaligned reads zero", 8'h0A, 0);

    // R8/R10: many bits, data-first write with stalled response
    irq_req_i = 16'hA5C3; tick(); irq_req_i = '0; tick();
    axi_rd("R10 pending pattern", 8'h00, 2);
    axi_wr(8'h04, 32'h0000_FFFF, 4'hF, 2, 3, -1);
    chk("R4 full clear", {16'h0, irq_o}, 32'h0);
    axi_rd("R10 pending empty", 8'h00, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule